// File: doc/BRIEF.md
# SPI Byte Controller with Single Transmit and Double Receive Buffering

The block moves one 8-bit character each way per transfer over a serial link: while the shift register pushes a byte out on `sd_out`, it takes a byte in from `sd_in`. The same shift register serves both directions. A write loads it directly, so transmit is single buffered. A completed byte is copied into a separate read register, so receive is double buffered and the next transfer can run while software still holds the previous byte.

`cfg_master` selects the role. As a master, the block makes the serial clock from a divider of the system clock and drives an active-low select. Only phase-0 timing is used in this role, and `cfg_cpol` picks the idle level. As a slave, the block follows an external serial clock and select, brought into the system clock domain through synchronizers, and handles all four polarity/phase pairs. Bytes travel most significant bit first.

Top module: `spi_byte_ctrl`

## Requirements
- R1: Each transfer shifts the written byte out MSB first on `sd_out` and collects 8 bits from `sd_in`, MSB first, into one received byte.
- R2: In master role, a write while idle starts a transfer. `busy` is high and `ss_out_n` is low for exactly 16*(cfg_div+1) clock cycles. `sclk_out` toggles every cfg_div+1 cycles and rests at `cfg_cpol` when idle.
- R3: In master role, `cfg_cpha` has no effect. Data is sampled on the leading `sclk_out` edge (the edge away from the idle level) and changed on the trailing edge.
- R4: In slave role, all four `cfg_cpol`/`cfg_cpha` pairs work. With phase 0, the MSB is on `sd_out` before the first edge, `sd_in` is sampled on leading edges and `sd_out` changes on trailing edges. With phase 1, `sd_out` changes on leading edges after the first one, and `sd_in` is sampled on trailing edges.
- R5: In slave role, `sclk_in` edges have no effect while `ss_in_n` is high, and the bit count restarts while the select is inactive.
- R6: At the end of a byte, the received value appears on `rd_data` and `rx_full` rises, in the same cycle that `busy` falls in master role. A one-cycle `rd_en` clears `rx_full` and `overrun`.
- R7: If a byte completes while `rx_full` is set, `overrun` goes high and `rd_data` keeps the older byte.
- R8: A write while `busy` is high is ignored: the byte in flight is unchanged and `wcol` rises on the next cycle. The next accepted write clears `wcol`.
- R9: After reset, `busy`, `rx_full`, `overrun` and `wcol` are 0, `ss_out_n` is 1 and `sclk_out` equals `cfg_cpol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 selects master role, 0 selects slave role |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase, used in slave role only |
| cfg_div | input | DIV_W (8) | Master half-period minus one, in system clock cycles |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | DATA_W (8) | Byte to transmit |
| rd_en | input | 1 | Acknowledges the received byte |
| rd_data | output | DATA_W (8) | Read buffer holding the last accepted byte |
| rx_full | output | 1 | Read buffer holds an unread byte |
| overrun | output | 1 | A byte was lost because the buffer was full |
| wcol | output | 1 | A write hit a running transfer |
| busy | output | 1 | Transfer in progress (master) or select active (slave) |
| sclk_out | output | 1 | Serial clock driven in master role |
| ss_out_n | output | 1 | Active-low select driven in master role |
| sclk_in | input | 1 | Serial clock received in slave role |
| ss_in_n | input | 1 | Active-low select received in slave role |
| sd_out | output | 1 | Serial data out |
| sd_in | input | 1 | Serial data in |

## Verification
In master role, `busy` goes high on the clock edge that accepts the write and falls exactly 16*(cfg_div+1) edges later. `rx_full` and `rd_data` update on that same edge. The bench counts falling-edge samples while `busy` is high and compares the count with this figure, and it checks the data right after `busy` drops. In slave role, a pin change reaches the shift logic on the third rising edge after it, so each received byte is due three edges after the final trailing clock edge. The bench holds every half period for six cycles and waits four cycles before it reads the result. `wcol` is due one edge after the colliding write and is checked at the next falling edge.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_LEAD  = 2'd1,
        EV_TRAIL = 2'd2
    } sclk_ev_e;

    // Map a raw clock transition onto leading/trailing for the given idle level.
    function automatic sclk_ev_e classify_edge(input logic rise, input logic fall, input logic idle_hi);
        if (rise) return idle_hi ? EV_TRAIL : EV_LEAD;
        if (fall) return idle_hi ? EV_LEAD : EV_TRAIL;
        return EV_NONE;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic ss_in_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic ss_active
);
    logic [STAGES-1:0] sck_sr_q;
    logic [STAGES-1:0] ss_sr_q;
    logic              sck_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_sr_q   <= '0;
            ss_sr_q    <= '1;
            sck_prev_q <= 1'b0;
        end else begin
            sck_sr_q   <= {sck_sr_q[STAGES-2:0], sclk_in};
            ss_sr_q    <= {ss_sr_q[STAGES-2:0], ss_in_n};
            sck_prev_q <= sck_sr_q[STAGES-1];
        end
    end

    assign sclk_rise = sck_sr_q[STAGES-1] & ~sck_prev_q;
    assign sclk_fall = ~sck_sr_q[STAGES-1] & sck_prev_q;
    assign ss_active = ~ss_sr_q[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run)         cnt_q <= '0;
        else if (cnt_q == div) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == div);
endmodule

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
    import spi_xfer_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_full,
    output logic              overrun,
    output logic              wcol,
    output logic              busy,
    output logic              sclk_out,
    output logic              ss_out_n,
    input  logic              sclk_in,
    input  logic              ss_in_n,
    output logic              sd_out,
    input  logic              sd_in
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] rbuf;
        logic              samp;
        logic [CNT_W-1:0]  bits;
        logic              run;
        logic              sclk;
        logic              full;
        logic              ovr;
        logic              wcol;
    } state_t;

    state_t q, d;

    logic     s_rise, s_fall, s_act, tick;
    logic     pha, xfer_busy, done, full_eff;
    sclk_ev_e ev;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (sclk_in),
        .ss_in_n   (ss_in_n),
        .sclk_rise (s_rise),
        .sclk_fall (s_fall),
        .ss_active (s_act)
    );

    spi_rate_gen #(.DIV_W(DIV_W)) u_rate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (cfg_master & q.run),
        .div  (cfg_div),
        .tick (tick)
    );

    always_comb begin
        d         = q;
        done      = 1'b0;
        pha       = cfg_master ? 1'b0 : cfg_cpha;
        xfer_busy = cfg_master ? q.run : s_act;
        full_eff  = q.full & ~rd_en;

        // Edge source: internal divider for master, synchronized pin for slave.
        if (cfg_master)
            ev = tick ? ((q.sclk == cfg_cpol) ? EV_LEAD : EV_TRAIL) : EV_NONE;
        else if (s_act)
            ev = classify_edge(s_rise, s_fall, cfg_cpol);
        else
            ev = EV_NONE;

        if (!cfg_master) begin
            d.run = 1'b0;
            if (!s_act) d.bits = '0;
        end
        if (!(cfg_master && q.run)) d.sclk = cfg_cpol;
        else if (tick)              d.sclk = ~q.sclk;

        case (ev)
            EV_LEAD: begin
                if (!pha)                d.samp = sd_in;
                else if (q.bits != '0)   d.sh   = {q.sh[DATA_W-2:0], q.samp};
            end
            EV_TRAIL: begin
                if (!pha) begin
                    d.sh = {q.sh[DATA_W-2:0], q.samp};
                end else begin
                    d.samp = sd_in;
                    if (q.bits == LAST_BIT) d.sh = {q.sh[DATA_W-2:0], sd_in};
                end
                d.bits = q.bits + 1'b1;
                if (q.bits == LAST_BIT) begin
                    done   = 1'b1;
                    d.bits = '0;
                    d.run  = 1'b0;
                end
            end
            default: ;
        endcase

        // Receive side: read buffer decoupled from the shift register.
        if (rd_en) begin
            d.full = 1'b0;
            d.ovr  = 1'b0;
        end
        if (done) begin
            if (full_eff) begin
                d.ovr = 1'b1;
            end else begin
                d.rbuf = d.sh;
                d.full = 1'b1;
            end
        end

        // Transmit side: only one holding place, so writes during a transfer bounce.
        if (wr_en) begin
            if (xfer_busy) begin
                d.wcol = 1'b1;
            end else begin
                d.wcol = 1'b0;
                d.sh   = wr_data;
                d.bits = '0;
                if (cfg_master) d.run = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sclk <= cfg_cpol;
        end else begin
            q <= d;
        end
    end

    assign rd_data  = q.rbuf;
    assign rx_full  = q.full;
    assign overrun  = q.ovr;
    assign wcol     = q.wcol;
    assign busy     = cfg_master ? q.run : s_act;
    assign sclk_out = q.sclk;
    assign ss_out_n = ~(cfg_master & q.run);
    assign sd_out   = q.sh[DATA_W-1];
endmodule

// File: rtl/spi_byte_ctrl_chk.sv
module spi_byte_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_master,
    input logic              cfg_cpol,
    input logic              wr_en,
    input logic              busy,
    input logic              sclk_out,
    input logic              ss_out_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              rx_full,
    input logic              overrun,
    input logic              wcol
);
    a_r8_wcol_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> wcol);

    a_r7_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(rd_data));

    a_r7_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> rx_full);

    a_r6_new_byte_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> rx_full);

    a_r2_select_during_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && busy) |-> !ss_out_n);

    a_r2_clock_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !busy && $past(!busy) && $stable(cfg_cpol)) |-> (sclk_out == cfg_cpol));
endmodule

bind spi_byte_ctrl spi_byte_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_master(cfg_master),
    .cfg_cpol  (cfg_cpol),
    .wr_en     (wr_en),
    .busy      (busy),
    .sclk_out  (sclk_out),
    .ss_out_n  (ss_out_n),
    .rd_data   (rd_data),
    .rx_full   (rx_full),
    .overrun   (overrun),
    .wcol      (wcol)
);

// File: tb/test_spi_byte_ctrl.sv
module test_spi_byte_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [7:0] cfg_div = 8'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       rx_full, overrun, wcol, busy, sclk_out, ss_out_n, sd_out;
    logic       sclk_in = 1'b0, ss_in_n = 1'b1, sd_in_s = 1'b0, sd_in_m = 1'b0;
    logic       sd_in;

    int n_checks = 0;
    int n_err = 0;

    logic [7:0] resp_m = 8'd0;
    logic [7:0] mosi_cap = 8'd0;
    int         bidx = 0;
    bit         m_act = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sd_in = cfg_master ? sd_in_m : sd_in_s;

    spi_byte_ctrl i_spi_byte_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_div(cfg_div), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_full(rx_full), .overrun(overrun),
        .wcol(wcol), .busy(busy), .sclk_out(sclk_out), .ss_out_n(ss_out_n),
        .sclk_in(sclk_in), .ss_in_n(ss_in_n), .sd_out(sd_out), .sd_in(sd_in)
    );

    // Model of a remote slave answering the design in master role.
    always @(negedge ss_out_n) begin
        sd_in_m = resp_m[7];
        bidx = 6;
    end
    always @(sclk_out) begin
        if (m_act && !ss_out_n) begin
            if (sclk_out != cfg_cpol) begin
                mosi_cap = {mosi_cap[6:0], sd_out};
            end else if (bidx >= 0) begin
                sd_in_m = resp_m[bidx];
                bidx = bidx - 1;
            end
        end
    end

    function automatic int exp_busy_cycles(input int div);
        return 16 * (div + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pop();
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
        check(rx_full == 1'b0 && overrun == 1'b0, "R6 read clears flags", {rx_full, overrun}, 0);
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rsp, input int div,
                               input logic pol, input logic pha_cfg, input bit collide,
                               input logic [7:0] exp_rd, input logic exp_ovr);
        int n;
        @(negedge clk);
        cfg_master = 1'b1; cfg_cpol = pol; cfg_cpha = pha_cfg; cfg_div = 8'(div);
        @(negedge clk);
        resp_m = rsp; mosi_cap = 8'd0; m_act = 1'b1;
        wr_data = tx; wr_en = 1'b1;
        @(negedge clk) wr_en = 1'b0;
        n = 0;
        while (busy && n < 5000) begin
            n++;
            if (collide && n == 5) begin wr_data = ~tx; wr_en = 1'b1; end
            if (collide && n == 6) begin
                wr_en = 1'b0;
                check(wcol == 1'b1, "R8 wcol after busy write", wcol, 1);
            end
            @(negedge clk);
        end
        m_act = 1'b0;
        check(n == exp_busy_cycles(div), "R2 busy length", n, exp_busy_cycles(div));
        check(mosi_cap == tx, "R1 R3 R8 bits sent on sd_out", mosi_cap, tx);
        check(rd_data == exp_rd, "R1 R6 R7 read buffer", rd_data, exp_rd);
        check(rx_full == 1'b1 && overrun == exp_ovr, "R6 R7 flags", {rx_full, overrun}, {1'b1, exp_ovr});
        check(sclk_out == pol && ss_out_n == 1'b1, "R2 idle clock and select", {sclk_out, ss_out_n}, {pol, 1'b1});
    endtask

    task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] mbyte, input logic pol, input logic pha);
        logic [7:0] cap;
        @(negedge clk);
        cfg_master = 1'b0; cfg_cpol = pol; cfg_cpha = pha;
        sclk_in = pol; ss_in_n = 1'b1;
        repeat (4) @(negedge clk);
        wr_data = tx; wr_en = 1'b1;
        @(negedge clk) wr_en = 1'b0;
        check(wcol == 1'b0, "R8 idle write accepted", wcol, 0);
        ss_in_n = 1'b0;
        cap = 8'd0;
        if (!pha) sd_in_s = mbyte[7];
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            sclk_in = ~pol;
            if (pha) sd_in_s = mbyte[7-i];
            else     cap = {cap[6:0], sd_out};
            repeat (HALF) @(negedge clk);
            sclk_in = pol;
            if (pha) cap = {cap[6:0], sd_out};
            else if (i < 7) sd_in_s = mbyte[6-i];
            repeat (HALF) @(negedge clk);
        end
        check(cap == tx, "R4 slave bits sent", cap, tx);
        check(rd_data == mbyte && rx_full == 1'b1, "R4 R6 slave received byte", rd_data, mbyte);
        ss_in_n = 1'b1;
        repeat (4) @(negedge clk);
        pop();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R9: reset values
        check(busy == 0 && rx_full == 0 && overrun == 0 && wcol == 0, "R9 reset flags",
              {busy, rx_full, overrun, wcol}, 0);
        check(ss_out_n == 1 && sclk_out == 0, "R9 reset select and clock", {ss_out_n, sclk_out}, 2'b10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Directed master cases, both polarities, phase bit ignored (R3)
        master_xfer(8'hA5, 8'h3C, 0, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0); pop();
        master_xfer(8'h81, 8'h7E, 2, 1'b1, 1'b0, 1'b0, 8'h7E, 1'b0); pop();
        master_xfer(8'h5A, 8'hC3, 1, 1'b0, 1'b1, 1'b0, 8'hC3, 1'b0); pop();

        // R8: colliding write leaves byte intact; later write clears wcol
        master_xfer(8'hF0, 8'h0F, 3, 1'b1, 1'b0, 1'b1, 8'h0F, 1'b0);
        check(wcol == 1'b1, "R8 wcol held", wcol, 1);
        pop();
        // R7: second byte without a read keeps the first
        master_xfer(8'h11, 8'h22, 0, 1'b0, 1'b0, 1'b0, 8'h22, 1'b0);
        check(wcol == 1'b0, "R8 accepted write clears wcol", wcol, 0);
        master_xfer(8'h33, 8'h44, 0, 1'b0, 1'b0, 1'b0, 8'h22, 1'b1);
        pop();

        // Random master transfers
        for (int k = 0; k < 6; k++) begin
            logic [7:0] t, r;
            t = 8'($urandom); r = 8'($urandom);
            master_xfer(t, r, int'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 1'b0, r, 1'b0);
            pop();
        end

        // Slave, each mode directed then random
        slave_xfer(8'hC6, 8'h39, 1'b0, 1'b0);
        slave_xfer(8'h93, 8'h6A, 1'b1, 1'b0);
        slave_xfer(8'h1E, 8'hE1, 1'b0, 1'b1);
        slave_xfer(8'hB4, 8'h4B, 1'b1, 1'b1);

        // R5: clock toggles with select inactive do nothing
        @(negedge clk);
        cfg_master = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; ss_in_n = 1'b1;
        for (int i = 0; i < 16; i++) begin
            sclk_in = ~sclk_in;
            repeat (HALF) @(negedge clk);
        end
        check(rx_full == 1'b0 && busy == 1'b0, "R5 ignored without select", {rx_full, busy}, 0);
        sclk_in = 1'b0;

        for (int k = 0; k < 8; k++) begin
            slave_xfer(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
        end
        // R5: after the ignored clocks a full byte still lines up
        slave_xfer(8'h0F, 8'hF0, 1'b0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule